// File: doc/BRIEF.md
# Accelerator Register Wrapper with Lock Semaphore

This block places a small fixed-function compute core behind a synchronous memory-style slave port. Software acquires exclusive use of the core by reading a lock register. The first read that returns 0 grants ownership, and that same read sets the lock. Any later read returns 1 until the owner writes the lock register to release it. The owner then loads two 16-bit operands and a 32-bit accumulator, writes the start command, and either polls the completion bit or waits for the level interrupt. After that it reads the return value and the saturation flag, and releases the lock.

The compute core is a signed saturating multiply-accumulate. It forms `acc + 2*a*b` and clamps the result to the signed 32-bit range. It reports whether clamping happened as an output parameter. Operand registers cannot change while the core is busy, and a start command that arrives during a computation is dropped.

Register map (word addresses on `addr`): 0 operand A (16 bits, reads zero-extended), 1 operand B (16 bits), 2 accumulator input (32 bits), 3 result (read-only), 4 lock, 5 control/status, 6 flags (read-only, bit 0 = saturated). Control/status bits are: bit 0 start (write 1 to start, always reads 0 once it has self-cleared), bit 1 interrupt enable (read/write), bit 2 busy (read-only), bit 3 done (read-only). Addresses 7 and above are unmapped.

Top module: `acc_regif_top`

## Requirements
- R1: Addresses 0, 1 and 2 store written data: 16 bits for 0 and 1, zero-extended on read, and 32 bits for 2. Writes to the result (3) and flags (6) addresses do not change them.
- R2: Read data appears on `rdata` in the cycle after the one in which `re` is sampled high. It is zero in a cycle after which `re` was low.
- R3: A read of address 4 returns the current lock bit in bit 0 and leaves the lock set. A read of a free lock returns 0, and any read of a held lock returns 1.
- R4: Any write to address 4 frees the lock. If a write and a read reach the lock in the same cycle, the write wins.
- R5: A write to address 5 with bit 0 set, while the block is not busy, starts a computation. `busy` is high from the next cycle. At the fifth rising edge after the start write, the result and flag registers are loaded, done (control bit 3) rises and `busy` falls.
- R6: The start bit clears itself one cycle after the write, so control bit 0 reads 0. The start write also clears done.
- R7: While `busy` is high, writes to addresses 0, 1 and 2 and further start commands are ignored.
- R8: `irq` is high exactly when done is set and the interrupt enable (control bit 1) is 1.
- R9: A read of an unmapped address returns zero and changes no register, including the lock.
- R10: The result equals `acc + 2*a*b` (signed), clamped to 0x7FFFFFFF or 0x80000000. Flag bit 0 is 1 exactly when clamping took place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr | input | 4 | Word address |
| we | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| re | input | 1 | Read strobe |
| rdata | output | 32 | Registered read data |
| busy | output | 1 | High from the accepted start until completion |
| irq | output | 1 | Level completion interrupt |

## Verification
On every cycle, the bound checker enforces several rules: the lock setting and clearing rules, the self-clearing start pulse, the clearing of done on start, the stability of operands during a computation, zero data after unmapped reads, and the completion rule that done is set whenever the core's busy falls. Only the bench's scenarios can show the arithmetic: the saturation corners, the exact five-edge completion latency seen at the ports, and the ownership sequence that software follows. Those are checked against a reference computed in the bench.

// File: rtl/acc_pkg.sv
package acc_pkg;
  localparam int ADR_OPA   = 0;
  localparam int ADR_OPB   = 1;
  localparam int ADR_ACC   = 2;
  localparam int ADR_RES   = 3;
  localparam int ADR_LOCK  = 4;
  localparam int ADR_CTRL  = 5;
  localparam int ADR_FLAG  = 6;

  localparam int CB_GO   = 0;
  localparam int CB_IEN  = 1;
  localparam int CB_BUSY = 2;
  localparam int CB_DONE = 3;
endpackage

// File: rtl/acc_rst_sync.sv
module acc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_s_n = sh_q[STAGES-1];
endmodule

// File: rtl/acc_lock.sv
module acc_lock (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_hit,
  input  logic wr_hit,
  output logic lock_q
);
  logic lock_d;
  logic lock_en;

  always_comb begin
    lock_en = rd_hit | wr_hit;
    lock_d  = ~wr_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       lock_q <= 1'b0;
    else if (lock_en) lock_q <= lock_d;
  end
endmodule

// File: rtl/acc_mac_core.sv
module acc_mac_core #(
  parameter int OP_W  = 16,
  parameter int RES_W = 32,
  parameter int LAT   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [OP_W-1:0]  op_a,
  input  logic [OP_W-1:0]  op_b,
  input  logic [RES_W-1:0] acc_in,
  output logic             busy,
  output logic             fin,
  output logic [RES_W-1:0] res,
  output logic             sat
);
  localparam int PROD_W = 2 * OP_W;
  localparam int WIDE_W = (RES_W > PROD_W + 1) ? RES_W : PROD_W + 1;
  localparam int SUM_W  = WIDE_W + 1;
  localparam int CNT_W  = $clog2(LAT) + 1;
  localparam logic signed [SUM_W-1:0] MAX_V = SUM_W'((64'd1 << (RES_W - 1)) - 64'd1);
  localparam logic signed [SUM_W-1:0] MIN_V = -MAX_V - SUM_W'(1);

  logic signed [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0]  sum;
  logic [RES_W-1:0]         res_d, res_q;
  logic                     sat_d, sat_q;
  logic                     busy_d, busy_q;
  logic [CNT_W-1:0]         cnt_d, cnt_q;

  always_comb begin
    prod = $signed(op_a) * $signed(op_b);
    sum  = (SUM_W'(prod) <<< 1) + SUM_W'($signed(acc_in));
    if (sum > MAX_V) begin
      res_d = RES_W'(MAX_V);
      sat_d = 1'b1;
    end else if (sum < MIN_V) begin
      res_d = RES_W'(MIN_V);
      sat_d = 1'b1;
    end else begin
      res_d = RES_W'(sum);
      sat_d = 1'b0;
    end
  end

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (start && !busy_q) begin
      busy_d = 1'b1;
      cnt_d  = CNT_W'(LAT - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      res_q  <= '0;
      sat_q  <= 1'b0;
    end else begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
      if (start && !busy_q) begin
        res_q <= res_d;
        sat_q <= sat_d;
      end
    end
  end

  assign busy = busy_q;
  assign fin  = busy_q & (cnt_q == '0);
  assign res  = res_q;
  assign sat  = sat_q;
endmodule

// File: rtl/acc_regif_top.sv
module acc_regif_top #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int OP_W   = 16,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  output logic [DATA_W-1:0] rdata,
  output logic              busy,
  output logic              irq
);
  import acc_pkg::*;

  logic              rst_s_n;
  logic              hit_opa, hit_opb, hit_acc, hit_res, hit_lock, hit_ctrl, hit_flag;
  logic              wr_ok;
  logic              go_wr;
  logic [OP_W-1:0]   opa_q, opa_d;
  logic [OP_W-1:0]   opb_q, opb_d;
  logic [DATA_W-1:0] acc_q, acc_d;
  logic [DATA_W-1:0] result_q, result_d;
  logic              flag_q, flag_d;
  logic              go_q, go_d;
  logic              done_q, done_d;
  logic              ien_q, ien_d;
  logic [DATA_W-1:0] rdata_q, rdata_d;
  logic              lock_q;
  logic              core_busy, core_fin, core_sat;
  logic [DATA_W-1:0] core_res;
  logic              busy_any;

  acc_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_s_n(rst_s_n)
  );

  always_comb begin
    hit_opa  = (addr == ADDR_W'(ADR_OPA));
    hit_opb  = (addr == ADDR_W'(ADR_OPB));
    hit_acc  = (addr == ADDR_W'(ADR_ACC));
    hit_res  = (addr == ADDR_W'(ADR_RES));
    hit_lock = (addr == ADDR_W'(ADR_LOCK));
    hit_ctrl = (addr == ADDR_W'(ADR_CTRL));
    hit_flag = (addr == ADDR_W'(ADR_FLAG));
  end

  acc_lock i_lock (
    .clk(clk), .rst_n(rst_s_n),
    .rd_hit(re & hit_lock), .wr_hit(we & hit_lock),
    .lock_q(lock_q)
  );

  acc_mac_core #(.OP_W(OP_W), .RES_W(DATA_W), .LAT(LAT)) i_core (
    .clk(clk), .rst_n(rst_s_n), .start(go_q),
    .op_a(opa_q), .op_b(opb_q), .acc_in(acc_q),
    .busy(core_busy), .fin(core_fin), .res(core_res), .sat(core_sat)
  );

  assign busy_any = go_q | core_busy;

  always_comb begin
    wr_ok    = we & ~busy_any;
    go_wr    = wr_ok & hit_ctrl & wdata[CB_GO];
    opa_d    = (wr_ok & hit_opa) ? wdata[OP_W-1:0] : opa_q;
    opb_d    = (wr_ok & hit_opb) ? wdata[OP_W-1:0] : opb_q;
    acc_d    = (wr_ok & hit_acc) ? wdata : acc_q;
    ien_d    = (we & hit_ctrl) ? wdata[CB_IEN] : ien_q;
    go_d     = go_wr;
    result_d = core_fin ? core_res : result_q;
    flag_d   = core_fin ? core_sat : flag_q;
    if (go_wr)         done_d = 1'b0;
    else if (core_fin) done_d = 1'b1;
    else               done_d = done_q;
  end

  always_comb begin
    rdata_d = '0;
    if (re) begin
      if (hit_opa)  rdata_d = DATA_W'(opa_q);
      if (hit_opb)  rdata_d = DATA_W'(opb_q);
      if (hit_acc)  rdata_d = acc_q;
      if (hit_res)  rdata_d = result_q;
      if (hit_lock) rdata_d = DATA_W'(lock_q);
      if (hit_ctrl) begin
        rdata_d[CB_GO]   = go_q;
        rdata_d[CB_IEN]  = ien_q;
        rdata_d[CB_BUSY] = busy_any;
        rdata_d[CB_DONE] = done_q;
      end
      if (hit_flag) rdata_d = DATA_W'(flag_q);
    end
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) begin
      opa_q    <= '0;
      opb_q    <= '0;
      acc_q    <= '0;
      result_q <= '0;
      flag_q   <= 1'b0;
      go_q     <= 1'b0;
      done_q   <= 1'b0;
      ien_q    <= 1'b0;
      rdata_q  <= '0;
    end else begin
      opa_q    <= opa_d;
      opb_q    <= opb_d;
      acc_q    <= acc_d;
      result_q <= result_d;
      flag_q   <= flag_d;
      go_q     <= go_d;
      done_q   <= done_d;
      ien_q    <= ien_d;
      rdata_q  <= rdata_d;
    end
  end

  assign rdata = rdata_q;
  assign busy  = busy_any;
  assign irq   = done_q & ien_q;
endmodule

// File: rtl/acc_regif_chk.sv
module acc_regif_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32,
  parameter int OP_W   = 16
) (
  input logic              clk,
  input logic              rst_s_n,
  input logic [ADDR_W-1:0] addr,
  input logic              we,
  input logic              re,
  input logic [DATA_W-1:0] rdata,
  input logic              lock_q,
  input logic              go_q,
  input logic              done_q,
  input logic              irq,
  input logic              busy,
  input logic              core_busy,
  input logic [OP_W-1:0]   opa_q,
  input logic [OP_W-1:0]   opb_q,
  input logic [DATA_W-1:0] acc_q
);
  import acc_pkg::*;

  AST_LOCK_SET_ON_READ: assert property (@(posedge clk) disable iff (!rst_s_n)
    (re && !we && addr == ADDR_W'(ADR_LOCK)) |=> lock_q); // R3
  AST_LOCK_FREE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_s_n)
    (we && addr == ADDR_W'(ADR_LOCK)) |=> !lock_q); // R4
  AST_GO_SELF_CLEAR: assert property (@(posedge clk) disable iff (!rst_s_n)
    go_q |=> !go_q); // R6
  AST_GO_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_s_n)
    go_q |-> !done_q); // R6
  AST_DONE_AT_FINISH: assert property (@(posedge clk) disable iff (!rst_s_n)
    $fell(core_busy) |-> done_q); // R5
  AST_OPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_s_n)
    busy |=> ($stable(opa_q) && $stable(opb_q) && $stable(acc_q))); // R7
  AST_IRQ_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_s_n)
    irq |-> done_q); // R8
  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_s_n)
    (re && addr > ADDR_W'(ADR_FLAG)) |=> (rdata == '0)); // R9
  AST_UNMAPPED_KEEPS_LOCK: assert property (@(posedge clk) disable iff (!rst_s_n)
    ((re || we) && addr > ADDR_W'(ADR_FLAG)) |=> $stable(lock_q)); // R9
endmodule

bind acc_regif_top acc_regif_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .OP_W(OP_W)) i_chk (
  .clk(clk), .rst_s_n(rst_s_n), .addr(addr), .we(we), .re(re), .rdata(rdata),
  .lock_q(lock_q), .go_q(go_q), .done_q(done_q), .irq(irq), .busy(busy),
  .core_busy(core_busy), .opa_q(opa_q), .opb_q(opb_q), .acc_q(acc_q)
);

// File: tb/test_acc_regif_top.sv
module test_acc_regif_top;
  logic        clk;
  logic        rst_n;
  logic [3:0]  addr;
  logic        we;
  logic [31:0] wdata;
  logic        re;
  logic [31:0] rdata;
  logic        busy;
  logic        irq;

  int checks;
  int fails;
  int cycles;

  acc_regif_top i_acc_regif_top (
    .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
    .re(re), .rdata(rdata), .busy(busy), .irq(irq)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  initial begin
    cycles = 0;
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        fails++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected<=100000 cycles", cycles);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; we = 1'b1;
    @(posedge clk);
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; re = 1'b1;
    @(posedge clk);
    @(negedge clk);
    d = rdata;
    re = 1'b0;
  endtask

  task automatic wait_done();
    logic [31:0] v;
    for (int n = 0; n < 50; n++) begin
      rd(4'd5, v);
      if (v[3]) break;
    end
  endtask

  function automatic logic [32:0] ref_mac(input logic [15:0] a, input logic [15:0] b, input logic [31:0] c);
    longint s;
    s = 2 * longint'($signed(a)) * longint'($signed(b)) + longint'($signed(c));
    if (s > 64'sd2147483647)       return {1'b1, 32'h7FFF_FFFF};
    else if (s < -64'sd2147483648) return {1'b1, 32'h8000_0000};
    else                           return {1'b0, s[31:0]};
  endfunction

  task automatic run_mac(input logic [15:0] a, input logic [15:0] b, input logic [31:0] c, input bit ien);
    logic [32:0] e;
    logic [31:0] v;
    e = ref_mac(a, b, c);
    wr(4'd0, {16'hABCD, a});
    wr(4'd1, {16'h1234, b});
    wr(4'd2, c);
    wr(4'd5, {30'd0, ien, 1'b1});
    wait_done();
    rd(4'd3, v);
    chk(v == e[31:0], "R10 result", v, e[31:0]);
    rd(4'd6, v);
    chk(v == {31'd0, e[32]}, "R10 saturation flag", v, {31'd0, e[32]});
    chk(irq == ien, "R8 irq level", {31'd0, irq}, {31'd0, ien});
  endtask

  initial begin
    logic [31:0] v;
    checks = 0; fails = 0;
    addr = '0; we = 1'b0; re = 1'b0; wdata = '0;
    rst_n = 1'b0;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // reset state
    rd(4'd5, v); chk(v == 32'd0, "R6 control after reset", v, 32'd0);
    chk(irq == 1'b0 && busy == 1'b0, "R8 irq/busy after reset", {30'd0, irq, busy}, 32'd0);
    rd(4'd3, v); chk(v == 32'd0, "R1 result after reset", v, 32'd0);
    chk(rdata == 32'd0, "R2 rdata zero without read", rdata, 32'd0);

    // lock protocol
    rd(4'd4, v); chk(v == 32'd0, "R3 first lock read grants", v, 32'd0);
    rd(4'd4, v); chk(v == 32'd1, "R3 second lock read denied", v, 32'd1);
    wr(4'd4, 32'd1);
    rd(4'd4, v); chk(v == 32'd0, "R4 lock freed by write", v, 32'd0);
    // simultaneous read and write: write wins
    addr = 4'd4; re = 1'b1; we = 1'b1;
    @(posedge clk); @(negedge clk);
    v = rdata; re = 1'b0; we = 1'b0;
    chk(v == 32'd1, "R4 read during release returns old", v, 32'd1);
    rd(4'd4, v); chk(v == 32'd0, "R4 write wins over read", v, 32'd0);
    wr(4'd4, 32'd0);

    // register readback and read-only
    wr(4'd0, 32'hFFFF_8001);
    rd(4'd0, v); chk(v == 32'h0000_8001, "R1 operand A 16-bit readback", v, 32'h0000_8001);
    wr(4'd2, 32'hDEAD_BEEF);
    rd(4'd2, v); chk(v == 32'hDEAD_BEEF, "R1 accumulator readback", v, 32'hDEAD_BEEF);
    wr(4'd3, 32'h5555_5555);
    rd(4'd3, v); chk(v == 32'd0, "R1 result read-only", v, 32'd0);
    wr(4'd6, 32'h1);
    rd(4'd6, v); chk(v == 32'd0, "R1 flags read-only", v, 32'd0);

    // unmapped addresses
    rd(4'd9, v); chk(v == 32'd0, "R9 unmapped read zero", v, 32'd0);
    wr(4'd12, 32'hFFFF_FFFF);
    rd(4'd15, v); chk(v == 32'd0, "R9 unmapped read zero hi", v, 32'd0);
    rd(4'd4, v); chk(v == 32'd0, "R9 lock untouched by unmapped", v, 32'd0);
    rd(4'd0, v); chk(v == 32'h0000_8001, "R9 operand untouched", v, 32'h0000_8001);
    wr(4'd4, 32'd0);

    // exact latency, busy window, writes ignored while busy
    wr(4'd0, 32'd3); wr(4'd1, 32'd5); wr(4'd2, 32'd7);
    wr(4'd5, 32'h3);
    chk(busy == 1'b1, "R5 busy after start", {31'd0, busy}, 32'd1);
    wr(4'd0, 32'd100);                       // edge k+1
    wr(4'd5, 32'h3);                         // edge k+2, start ignored
    rd(4'd5, v);                             // edge k+3
    chk(v == 32'h6, "R6 start reads 0, busy set, done clear", v, 32'h6);
    @(posedge clk); @(negedge clk);          // edge k+4
    chk(irq == 1'b0 && busy == 1'b1, "R5 not done before fifth edge", {30'd0, irq, busy}, 32'd1);
    @(posedge clk); @(negedge clk);          // edge k+5
    chk(irq == 1'b1 && busy == 1'b0, "R5 done at fifth edge", {30'd0, irq, busy}, 32'd2);
    @(posedge clk); @(negedge clk);
    chk(busy == 1'b0, "R7 ignored start did not restart", {31'd0, busy}, 32'd0);
    rd(4'd3, v); chk(v == 32'd37, "R5 result 7+2*3*5", v, 32'd37);
    rd(4'd0, v); chk(v == 32'd3, "R7 operand write ignored while busy", v, 32'd3);

    // start clears done; ien low masks irq
    wr(4'd5, 32'h1);
    rd(4'd5, v); chk(v[3] == 1'b0, "R6 start clears done", v, 32'h4);
    wait_done();
    chk(irq == 1'b0, "R8 irq masked with enable low", {31'd0, irq}, 32'd0);
    wr(4'd5, 32'h2);
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq follows enable", {31'd0, irq}, 32'd1);

    // saturation corners
    run_mac(16'h8000, 16'h8000, 32'd0, 1'b1);
    run_mac(16'h0001, 16'hFFFF, 32'h8000_0000, 1'b0);
    run_mac(16'h7FFF, 16'h7FFF, 32'h7FFF_0000, 1'b1);
    run_mac(16'hFFFF, 16'h0002, 32'd5, 1'b0);

    // random stimulus
    for (int i = 0; i < 30; i++) begin
      logic [15:0] a, b;
      logic [31:0] c;
      a = 16'($urandom);
      b = 16'($urandom);
      c = (i % 5 == 0) ? {$urandom_range(1) != 0 ? 2'b10 : 2'b01, 30'($urandom)} : $urandom;
      rd(4'd4, v); chk(v == 32'd0, "R3 acquire before job", v, 32'd0);
      run_mac(a, b, c, i[0]);
      wr(4'd4, 32'd0);
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule